// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits at the input of the execute stage of a five-stage pipelined core. For each of the two execute operands it picks one source: an immediate from the instruction, a result still in flight in the EX/MEM pipeline register, a result in the MEM/WB pipeline register, or the value read from the register file. It compares the operand's 3-bit source index with the destination index and write enable of each later stage. It then outputs a 2-bit select code and the chosen 32-bit value.

The condition flags follow the same idea. A conditional branch directly behind a flag-setting instruction must see the new flags before they reach the flag register. So the block also chooses between flags produced in EX/MEM, flags produced in MEM/WB and the architectural flag register. When MEM/WB holds a load, the value forwarded from that stage is the memory read data rather than the ALU result. Every output is registered, so the choices made on the inputs at one clock edge appear after that edge.

Top module: `opfwd_sel`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Outputs are registered. A change on any input does not reach the outputs before the next rising edge. After that edge, the outputs reflect the inputs sampled at the edge.
- R3: When an operand's immediate flag is set, its select is 2'b11 and its value is `ex_imm`. This holds whatever the forwarding matches are.
- R4: With no immediate, when `xm_wr_en` is 1 and `xm_wr_idx` equals the operand's source index, the select is 2'b10 and the value is `xm_alu_res`.
- R5: When both EX/MEM and MEM/WB match the same operand, the EX/MEM path wins (select 2'b10).
- R6: With no immediate and no EX/MEM match, when `mw_wr_en` is 1 and `mw_wr_idx` equals the source index, the select is 2'b01. The value is `mw_alu_res` when `mw_is_load` is 0.
- R7: When the MEM/WB path is selected and `mw_is_load` is 1, the operand value is `mw_mem_data`.
- R8: Otherwise the select is 2'b00 and the value is the operand's register-file read data. An index match whose write enable is 0 has no effect.
- R9: Index 0 is an ordinary register: a match on index 0 forwards exactly as any other index does.
- R10: Flag select is 2'b10 with `xm_flg` when `xm_flg_en` is 1. Otherwise it is 2'b01 with `mw_flg` when `mw_flg_en` is 1. Otherwise it is 2'b00 with `arch_flg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_src_a | input | 3 | Source index of operand A |
| ex_src_b | input | 3 | Source index of operand B |
| ex_imm_a_en | input | 1 | Operand A takes the immediate |
| ex_imm_b_en | input | 1 | Operand B takes the immediate |
| ex_imm | input | 32 | Immediate value of the execute instruction |
| rf_rd_a | input | 32 | Register-file read data for operand A |
| rf_rd_b | input | 32 | Register-file read data for operand B |
| xm_wr_en | input | 1 | EX/MEM instruction writes a register |
| xm_wr_idx | input | 3 | EX/MEM destination index |
| xm_alu_res | input | 32 | EX/MEM result |
| xm_flg_en | input | 1 | EX/MEM instruction updates flags |
| xm_flg | input | 3 | EX/MEM flags |
| mw_wr_en | input | 1 | MEM/WB instruction writes a register |
| mw_wr_idx | input | 3 | MEM/WB destination index |
| mw_alu_res | input | 32 | MEM/WB ALU result |
| mw_mem_data | input | 32 | MEM/WB memory read data |
| mw_is_load | input | 1 | MEM/WB instruction is a load |
| mw_flg_en | input | 1 | MEM/WB instruction updates flags |
| mw_flg | input | 3 | MEM/WB flags |
| arch_flg | input | 3 | Architectural flag register |
| sel_a | output | 2 | Operand A select code |
| sel_b | output | 2 | Operand B select code |
| opnd_a | output | 32 | Operand A value |
| opnd_b | output | 32 | Operand B value |
| flg_sel | output | 2 | Flag source code |
| flg_out | output | 3 | Forwarded flags |

## Verification
The cases that matter most are those where several sources claim one operand in the same cycle. These are an EX/MEM and a MEM/WB match on the same index, and an immediate that also has both matches. The bench provokes them by directed vectors that put both destinations on the operand's index. Random stimulus also ties destinations to sources often. Each result is judged against a bench priority function, and the select code shows which path won. The flag path is stressed the same way, with both flag enables high together.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MW  = 2'b01,
    SEL_XM  = 2'b10,
    SEL_IMM = 2'b11
  } opnd_sel_e;

  typedef enum logic [1:0] {
    FSEL_ARCH = 2'b00,
    FSEL_MW   = 2'b01,
    FSEL_XM   = 2'b10
  } flag_sel_e;
endpackage

// File: rtl/opfwd_operand.sv
module opfwd_operand
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  src,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              xm_wen,
  input  logic [IDX_W-1:0]  xm_dst,
  input  logic [DATA_W-1:0] xm_val,
  input  logic              mw_wen,
  input  logic [IDX_W-1:0]  mw_dst,
  input  logic [DATA_W-1:0] mw_val,
  output logic [1:0]        sel_q,
  output logic [DATA_W-1:0] opnd_q
);
  logic              xm_hit, mw_hit;
  opnd_sel_e         sel_d;
  logic [DATA_W-1:0] opnd_d;

  // index 0 is not excluded: every register is writable
  assign xm_hit = xm_wen && (xm_dst == src);
  assign mw_hit = mw_wen && (mw_dst == src);

  always_comb begin
    if (use_imm) begin
      sel_d  = SEL_IMM;
      opnd_d = imm;
    end else if (xm_hit) begin
      sel_d  = SEL_XM;
      opnd_d = xm_val;
    end else if (mw_hit) begin
      sel_d  = SEL_MW;
      opnd_d = mw_val;
    end else begin
      sel_d  = SEL_RF;
      opnd_d = rf_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 2'b00;
      opnd_q <= '0;
    end else begin
      sel_q  <= sel_d;
      opnd_q <= opnd_d;
    end
  end

  p_imm_wins_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(use_imm)) |-> (sel_q == 2'b11 && opnd_q == $past(imm)));

  // R5: EX/MEM beats MEM/WB when both match
  p_xm_first_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!use_imm && xm_wen && xm_dst == src))
      |-> (sel_q == 2'b10 && opnd_q == $past(xm_val)));

  p_mw_path_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!use_imm && !(xm_wen && xm_dst == src) && mw_wen && mw_dst == src))
      |-> (sel_q == 2'b01 && opnd_q == $past(mw_val)));

  p_rf_default_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!use_imm && !(xm_wen && xm_dst == src) && !(mw_wen && mw_dst == src)))
      |-> (sel_q == 2'b00 && opnd_q == $past(rf_val)));
endmodule

// File: rtl/opfwd_flags.sv
module opfwd_flags
  import opfwd_pkg::*;
#(
  parameter int FLAG_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xm_en,
  input  logic [FLAG_W-1:0] xm_flg,
  input  logic              mw_en,
  input  logic [FLAG_W-1:0] mw_flg,
  input  logic [FLAG_W-1:0] arch_flg,
  output logic [1:0]        sel_q,
  output logic [FLAG_W-1:0] flg_q
);
  flag_sel_e         sel_d;
  logic [FLAG_W-1:0] flg_d;

  always_comb begin
    if (xm_en) begin
      sel_d = FSEL_XM;
      flg_d = xm_flg;
    end else if (mw_en) begin
      sel_d = FSEL_MW;
      flg_d = mw_flg;
    end else begin
      sel_d = FSEL_ARCH;
      flg_d = arch_flg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 2'b00;
      flg_q <= '0;
    end else begin
      sel_q <= sel_d;
      flg_q <= flg_d;
    end
  end

  p_flag_xm_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(xm_en)) |-> (sel_q == 2'b10 && flg_q == $past(xm_flg)));

  p_flag_mw_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!xm_en && mw_en)) |-> (sel_q == 2'b01 && flg_q == $past(mw_flg)));

  p_flag_arch_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!xm_en && !mw_en)) |-> (sel_q == 2'b00 && flg_q == $past(arch_flg)));
endmodule

// File: rtl/opfwd_sel.sv
module opfwd_sel
  import opfwd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 8,
  parameter int FLAG_W  = 3,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ex_src_a,
  input  logic [IDX_W-1:0]  ex_src_b,
  input  logic              ex_imm_a_en,
  input  logic              ex_imm_b_en,
  input  logic [DATA_W-1:0] ex_imm,
  input  logic [DATA_W-1:0] rf_rd_a,
  input  logic [DATA_W-1:0] rf_rd_b,
  input  logic              xm_wr_en,
  input  logic [IDX_W-1:0]  xm_wr_idx,
  input  logic [DATA_W-1:0] xm_alu_res,
  input  logic              xm_flg_en,
  input  logic [FLAG_W-1:0] xm_flg,
  input  logic              mw_wr_en,
  input  logic [IDX_W-1:0]  mw_wr_idx,
  input  logic [DATA_W-1:0] mw_alu_res,
  input  logic [DATA_W-1:0] mw_mem_data,
  input  logic              mw_is_load,
  input  logic              mw_flg_en,
  input  logic [FLAG_W-1:0] mw_flg,
  input  logic [FLAG_W-1:0] arch_flg,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [1:0]        flg_sel,
  output logic [FLAG_W-1:0] flg_out
);
  localparam int N_OPND = 2;

  logic [DATA_W-1:0] mw_fwd_val;
  logic [IDX_W-1:0]  src_v  [N_OPND];
  logic              imm_v  [N_OPND];
  logic [DATA_W-1:0] rf_v   [N_OPND];
  logic [1:0]        sel_v  [N_OPND];
  logic [DATA_W-1:0] opnd_v [N_OPND];

  // a load in MEM/WB forwards the data read from memory
  assign mw_fwd_val = mw_is_load ? mw_mem_data : mw_alu_res;

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign imm_v[0] = ex_imm_a_en;
  assign imm_v[1] = ex_imm_b_en;
  assign rf_v[0]  = rf_rd_a;
  assign rf_v[1]  = rf_rd_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    opfwd_operand #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) u_opnd (
      .clk     (clk),
      .rst     (rst),
      .src     (src_v[g]),
      .use_imm (imm_v[g]),
      .imm     (ex_imm),
      .rf_val  (rf_v[g]),
      .xm_wen  (xm_wr_en),
      .xm_dst  (xm_wr_idx),
      .xm_val  (xm_alu_res),
      .mw_wen  (mw_wr_en),
      .mw_dst  (mw_wr_idx),
      .mw_val  (mw_fwd_val),
      .sel_q   (sel_v[g]),
      .opnd_q  (opnd_v[g])
    );
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];

  opfwd_flags #(
    .FLAG_W (FLAG_W)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .xm_en    (xm_flg_en),
    .xm_flg   (xm_flg),
    .mw_en    (mw_flg_en),
    .mw_flg   (mw_flg),
    .arch_flg (arch_flg),
    .sel_q    (flg_sel),
    .flg_q    (flg_out)
  );

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_a == 2'b00 && sel_b == 2'b00 && opnd_a == '0 && opnd_b == '0
                    && flg_sel == 2'b00 && flg_out == '0));

  p_load_data_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mw_is_load) && sel_a == 2'b01) |-> (opnd_a == $past(mw_mem_data)));

  p_alu_data_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!mw_is_load) && sel_b == 2'b01) |-> (opnd_b == $past(mw_alu_res)));
endmodule

// File: tb/sim_opfwd_sel.sv
`timescale 1ns/1ps
module sim_opfwd_sel;
  localparam int DW = 32;
  localparam int IW = 3;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst;
  logic [IW-1:0] ex_src_a, ex_src_b;
  logic ex_imm_a_en, ex_imm_b_en;
  logic [DW-1:0] ex_imm, rf_rd_a, rf_rd_b;
  logic xm_wr_en;
  logic [IW-1:0] xm_wr_idx;
  logic [DW-1:0] xm_alu_res;
  logic xm_flg_en;
  logic [FW-1:0] xm_flg;
  logic mw_wr_en;
  logic [IW-1:0] mw_wr_idx;
  logic [DW-1:0] mw_alu_res, mw_mem_data;
  logic mw_is_load, mw_flg_en;
  logic [FW-1:0] mw_flg, arch_flg;
  logic [1:0] sel_a, sel_b, flg_sel;
  logic [DW-1:0] opnd_a, opnd_b;
  logic [FW-1:0] flg_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opfwd_sel u0 (
    .clk(clk), .rst(rst),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_imm_a_en(ex_imm_a_en), .ex_imm_b_en(ex_imm_b_en),
    .ex_imm(ex_imm), .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b),
    .xm_wr_en(xm_wr_en), .xm_wr_idx(xm_wr_idx), .xm_alu_res(xm_alu_res),
    .xm_flg_en(xm_flg_en), .xm_flg(xm_flg),
    .mw_wr_en(mw_wr_en), .mw_wr_idx(mw_wr_idx), .mw_alu_res(mw_alu_res),
    .mw_mem_data(mw_mem_data), .mw_is_load(mw_is_load),
    .mw_flg_en(mw_flg_en), .mw_flg(mw_flg), .arch_flg(arch_flg),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flg_sel(flg_sel), .flg_out(flg_out)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] f_sel(logic [IW-1:0] s, logic im);
    if (im) return 2'b11;
    if (xm_wr_en && xm_wr_idx == s) return 2'b10;
    if (mw_wr_en && mw_wr_idx == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] f_val(logic [1:0] sel, logic [DW-1:0] rf);
    case (sel)
      2'b11:   return ex_imm;
      2'b10:   return xm_alu_res;
      2'b01:   return mw_is_load ? mw_mem_data : mw_alu_res;
      default: return rf;
    endcase
  endfunction

  function automatic string f_tag(logic [1:0] sel);
    case (sel)
      2'b11:   return "R3";
      2'b10:   return (mw_wr_en && mw_wr_idx == xm_wr_idx) ? "R5" : "R4";
      2'b01:   return mw_is_load ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  // inputs are held since before the edge; compare after it
  task automatic step();
    logic [1:0] ea, eb, ef;
    logic [FW-1:0] fv;
    ea = f_sel(ex_src_a, ex_imm_a_en);
    eb = f_sel(ex_src_b, ex_imm_b_en);
    if (xm_flg_en) begin ef = 2'b10; fv = xm_flg; end
    else if (mw_flg_en) begin ef = 2'b01; fv = mw_flg; end
    else begin ef = 2'b00; fv = arch_flg; end
    @(posedge clk);
    #1;
    chk({f_tag(ea), " sel_a"}, DW'(sel_a), DW'(ea));
    chk({f_tag(ea), " opnd_a"}, opnd_a, f_val(ea, rf_rd_a));
    chk({f_tag(eb), " sel_b"}, DW'(sel_b), DW'(eb));
    chk({f_tag(eb), " opnd_b"}, opnd_b, f_val(eb, rf_rd_b));
    chk("R10 flg_sel", DW'(flg_sel), DW'(ef));
    chk("R10 flg_out", DW'(flg_out), DW'(fv));
  endtask

  task automatic clear_in();
    ex_src_a = 3'd1; ex_src_b = 3'd2; ex_imm_a_en = 0; ex_imm_b_en = 0;
    ex_imm = 32'hAAAA_0001; rf_rd_a = 32'h1111_1111; rf_rd_b = 32'h2222_2222;
    xm_wr_en = 0; xm_wr_idx = 0; xm_alu_res = 32'h3333_3333; xm_flg_en = 0; xm_flg = 3'b101;
    mw_wr_en = 0; mw_wr_idx = 0; mw_alu_res = 32'h4444_4444; mw_mem_data = 32'h5555_5555;
    mw_is_load = 0; mw_flg_en = 0; mw_flg = 3'b011; arch_flg = 3'b110;
  endtask

  task automatic rand_in();
    ex_src_a = IW'($urandom); ex_src_b = IW'($urandom);
    ex_imm_a_en = ($urandom % 6) == 0; ex_imm_b_en = ($urandom % 4) == 0;
    ex_imm = $urandom; rf_rd_a = $urandom; rf_rd_b = $urandom;
    xm_wr_en = $urandom; mw_wr_en = $urandom;
    xm_wr_idx = ($urandom % 2) ? ex_src_a : IW'($urandom);
    mw_wr_idx = ($urandom % 2) ? ex_src_b : (($urandom % 2) ? xm_wr_idx : IW'($urandom));
    xm_alu_res = $urandom; mw_alu_res = $urandom; mw_mem_data = $urandom;
    mw_is_load = $urandom; xm_flg_en = $urandom; mw_flg_en = $urandom;
    xm_flg = FW'($urandom); mw_flg = FW'($urandom); arch_flg = FW'($urandom);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    void'($urandom(32'd2024));
    // R1: reset with every path trying to match
    rst = 1'b1;
    clear_in();
    xm_wr_en = 1; xm_wr_idx = 3'd1; mw_wr_en = 1; mw_wr_idx = 3'd2;
    xm_flg_en = 1; ex_imm_b_en = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 sel_a", DW'(sel_a), 0);
    chk("R1 opnd_a", opnd_a, 0);
    chk("R1 sel_b", DW'(sel_b), 0);
    chk("R1 opnd_b", opnd_b, 0);
    chk("R1 flg_sel", DW'(flg_sel), 0);
    chk("R1 flg_out", DW'(flg_out), 0);
    rst = 1'b0;

    // R8: matching index but write enables low
    clear_in();
    xm_wr_idx = 3'd1; mw_wr_idx = 3'd2;
    step();
    // R4 and R6 on separate operands
    xm_wr_en = 1; mw_wr_en = 1;
    step();
    // R9: index 0 forwards
    clear_in();
    ex_src_a = 0; ex_src_b = 0; xm_wr_en = 1; xm_wr_idx = 0;
    step();
    chk("R9 sel_a idx0", DW'(sel_a), 2);
    // R5: both stages match both operands
    clear_in();
    ex_src_a = 3'd5; ex_src_b = 3'd5;
    xm_wr_en = 1; xm_wr_idx = 3'd5; mw_wr_en = 1; mw_wr_idx = 3'd5;
    step();
    // R3: immediate over both matches
    ex_imm_a_en = 1;
    step();
    // R7: load in MEM/WB
    clear_in();
    ex_src_a = 3'd7; mw_wr_en = 1; mw_wr_idx = 3'd7; mw_is_load = 1;
    step();
    chk("R7 load data", opnd_a, 32'h5555_5555);
    // R10: both flag enables, then only MEM/WB, then neither
    xm_flg_en = 1; mw_flg_en = 1;
    step();
    xm_flg_en = 0;
    step();
    mw_flg_en = 0;
    step();
    // R2: a new input is not visible before the edge
    held = sel_a;
    ex_imm_a_en = 1;
    #1;
    chk("R2 before edge", DW'(sel_a), DW'(held));
    step();

    for (int i = 0; i < 2000; i++) begin
      rand_in();
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule